// File: doc/BRIEF.md
# Single-Wire Bus Slave Instruction Decoder

This block is the device end of a host-driven serial bus that shares one open-drain wire. A bit recovery stage, outside this block, turns each bit slot into a one-cycle strobe plus a sampled line value. The decoder gathers a 16-bit instruction, checks the device-select bit against a strap pin and decodes a two-bit operation. A write takes one more byte from the host and commits it through a register-file write port. A read fetches a byte through the register-file read port and returns it, optionally followed by a CRC-8 byte. The block only ever pulls the line low. It never starts a transfer.

Instruction word, first bit on the wire first: bits [15:14] operation, bit [13] device select, bit [12] don't-care, bits [11:8] bank, bits [7:0] register offset. The register address presented on the port is {bank, offset}. Strobes must be at least three clock cycles apart.

Top module: `sw_slave_decoder`

## Requirements
- R1: After reset deassertion, drv_low_o, reg_we_o, reg_re_o and bus_err_o are all 0.
- R2: The instruction is received MSB first as 16 strobed bits, with operation in bits [15:14], select in [13], bank in [11:8] and offset in [7:0]; reg_addr_o carries {bank, offset} during the resulting register access.
- R3: Operation 2'b00 with matching select takes 8 further bits MSB first and then pulses reg_we_o for exactly one cycle, with reg_wdata_o equal to that byte.
- R4: Operation 2'b01 with matching select pulses reg_re_o for exactly one cycle and then returns reg_rdata_i over the next 8 slots MSB first, holding drv_low_o high during a slot exactly when that bit is 0.
- R5: Operation 2'b10 behaves as R4 and then returns 8 more bits: CRC-8 of the data byte, polynomial 0x07, initial value 0x00, no reflection, MSB first.
- R6: When bit [13] differs from dev_sel_i, the transaction causes no write, read, error or line drive, and the following 8 slots (2'b00, 2'b01), 16 slots (2'b10) or 0 slots (2'b11) are consumed so the next instruction decodes correctly.
- R7: Operation 2'b11 with matching select pulses bus_err_o for one cycle, drives nothing, and the very next strobe begins a new instruction.
- R8: drv_low_o is 0 at every moment outside the data and CRC slots of an addressed read.
- R9: Bit [12] has no effect on decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_stb_i | input | 1 | One-cycle strobe per recovered bit slot |
| bit_i | input | 1 | Sampled line level for the strobed slot |
| dev_sel_i | input | 1 | Strap selecting which of the two device identities this slave answers |
| drv_low_o | output | 1 | Open-drain pull-down enable |
| reg_addr_o | output | 12 | Register address {bank, offset} |
| reg_we_o | output | 1 | Register write pulse |
| reg_wdata_o | output | 8 | Register write data |
| reg_re_o | output | 1 | Register read pulse; data sampled the same cycle |
| reg_rdata_i | input | 8 | Register read data |
| bus_err_o | output | 1 | Reserved-operation error pulse |

## Verification
A wrong bit count or state at the slave shows up almost immediately: a slip of one bit in the instruction shifts every field, so the next access goes to a wrong address or uses a wrong operation within that same instruction. A mismatched skip length leaves the decoder out of step with the host. The next instruction then decodes as garbage, so every transaction is followed by another that relies on framing. Read data and CRC errors appear on drv_low_o in the slot of the bad bit, and a stray pull-down on a transaction that belongs to the other device is caught by a per-transaction count of drive cycles.

// File: rtl/sw_slv_pkg.sv
package sw_slv_pkg;
  localparam int unsigned FRAME_W = 16;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned BANK_W  = 4;
  localparam int unsigned OFFS_W  = 8;
  localparam int unsigned ADDR_W  = BANK_W + OFFS_W;
  localparam int unsigned CNT_W   = $clog2(2 * FRAME_W);

  typedef enum logic [1:0] {
    OP_WR  = 2'b00,
    OP_RD  = 2'b01,
    OP_RDC = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  typedef struct packed {
    op_e               op;
    logic              dev;
    logic              rsv;
    logic [BANK_W-1:0] bank;
    logic [OFFS_W-1:0] offs;
  } frame_t;

  typedef enum logic [2:0] {
    ST_FRAME,
    ST_WDATA,
    ST_WRITE,
    ST_RDREQ,
    ST_TX,
    ST_SKIP
  } state_e;
endpackage

// File: rtl/sw_shift_in.sv
module sw_shift_in #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             stb_i,
  input  logic             bit_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      cnt_o  <= '0;
    end else if (clr_i) begin
      cnt_o  <= '0;
    end else if (stb_i) begin
      data_o <= {data_o[W-2:0], bit_i};
      cnt_o  <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/sw_crc8.sv
module sw_crc8 #(
  parameter int unsigned W    = 8,
  parameter logic [7:0]  POLY = 8'h07,
  parameter logic [7:0]  INIT = 8'h00
) (
  input  logic [W-1:0] data_i,
  output logic [7:0]   crc_o
);
  always_comb begin
    logic [7:0] c;
    c = INIT;
    for (int i = W - 1; i >= 0; i--) begin
      if (c[7] ^ data_i[i]) c = {c[6:0], 1'b0} ^ POLY;
      else                  c = {c[6:0], 1'b0};
    end
    crc_o = c;
  end
endmodule

// File: rtl/sw_shift_out.sv
module sw_shift_out #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [W-1:0]     data_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             stb_i,
  output logic             bit_o,
  output logic             busy_o,
  output logic             last_o
);
  logic [W-1:0]     sh_q;
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      rem_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      rem_q <= len_i;
    end else if (stb_i && rem_q != '0) begin
      sh_q  <= {sh_q[W-2:0], 1'b1};
      rem_q <= rem_q - 1'b1;
    end
  end

  assign bit_o  = sh_q[W-1];
  assign busy_o = (rem_q != '0);
  assign last_o = (rem_q == CNT_W'(1));
endmodule

// File: rtl/sw_slave_decoder.sv
module sw_slave_decoder
  import sw_slv_pkg::*;
#(
  parameter logic [7:0] CRC_POLY = 8'h07,
  parameter logic [7:0] CRC_INIT = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  input  logic              dev_sel_i,
  output logic              drv_low_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              bus_err_o
);
  localparam int unsigned TX_W = 2 * DATA_W;

  state_e             st_q;
  frame_t             frm_q, frm_w;
  logic [FRAME_W-1:0] rx_q, rx_next;
  logic [CNT_W-1:0]   cnt, lim, skip_q, skip_len;
  logic               last_bit, rx_clr, err_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [7:0]         crc;
  logic               tx_bit, tx_busy, tx_last, tx_load;
  logic [TX_W-1:0]    tx_data;
  logic [CNT_W-1:0]   tx_len;

  sw_shift_in #(.W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk_i, .rst_ni, .clr_i(rx_clr), .stb_i(bit_stb_i), .bit_i,
    .data_o(rx_q), .cnt_o(cnt)
  );

  assign rx_next = {rx_q[FRAME_W-2:0], bit_i};
  assign frm_w   = frame_t'(rx_next);

  always_comb begin
    unique case (st_q)
      ST_WDATA: lim = CNT_W'(DATA_W);
      ST_SKIP:  lim = skip_q;
      default:  lim = CNT_W'(FRAME_W);
    endcase
  end

  assign last_bit = bit_stb_i && (cnt == lim - 1'b1) &&
                    (st_q inside {ST_FRAME, ST_WDATA, ST_SKIP});
  // strobes outside receive states must not advance the counter
  assign rx_clr   = last_bit || (st_q inside {ST_WRITE, ST_RDREQ, ST_TX});

  // bits owned by the other device after its instruction
  always_comb begin
    unique case (frm_w.op)
      OP_WR, OP_RD: skip_len = CNT_W'(DATA_W);
      OP_RDC:       skip_len = CNT_W'(2 * DATA_W);
      default:      skip_len = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_FRAME;
      frm_q   <= '0;
      skip_q  <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (st_q)
        ST_FRAME: if (last_bit) begin
          frm_q <= frm_w;
          if (frm_w.dev != dev_sel_i) begin
            skip_q <= skip_len;
            st_q   <= (skip_len != '0) ? ST_SKIP : ST_FRAME;
          end else begin
            unique case (frm_w.op)
              OP_WR:         st_q <= ST_WDATA;
              OP_RD, OP_RDC: st_q <= ST_RDREQ;
              default: begin
                err_q <= 1'b1;
                st_q  <= ST_FRAME;
              end
            endcase
          end
        end
        ST_WDATA: if (last_bit) begin
          wdata_q <= rx_next[DATA_W-1:0];
          st_q    <= ST_WRITE;
        end
        ST_WRITE: st_q <= ST_FRAME;
        ST_RDREQ: st_q <= ST_TX;
        ST_TX:    if (bit_stb_i && tx_last) st_q <= ST_FRAME;
        ST_SKIP:  if (last_bit) st_q <= ST_FRAME;
        default:  st_q <= ST_FRAME;
      endcase
    end
  end

  sw_crc8 #(.W(DATA_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .data_i(reg_rdata_i), .crc_o(crc)
  );

  assign tx_load = (st_q == ST_RDREQ);
  assign tx_data = (frm_q.op == OP_RDC) ? {reg_rdata_i, crc} : {reg_rdata_i, 8'hFF};
  assign tx_len  = (frm_q.op == OP_RDC) ? CNT_W'(2 * DATA_W) : CNT_W'(DATA_W);

  sw_shift_out #(.W(TX_W), .CNT_W(CNT_W)) u_tx (
    .clk_i, .rst_ni, .load_i(tx_load), .data_i(tx_data), .len_i(tx_len),
    .stb_i(bit_stb_i && st_q == ST_TX), .bit_o(tx_bit), .busy_o(tx_busy),
    .last_o(tx_last)
  );

  assign drv_low_o   = (st_q == ST_TX) && tx_busy && !tx_bit;
  assign reg_addr_o  = {frm_q.bank, frm_q.offs};
  assign reg_we_o    = (st_q == ST_WRITE);
  assign reg_wdata_o = wdata_q;
  assign reg_re_o    = (st_q == ST_RDREQ);
  assign bus_err_o   = err_q;
endmodule

// File: rtl/sw_slave_decoder_chk.sv
module sw_slave_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_stb_i,
  input logic drv_low_o,
  input logic reg_we_o,
  input logic reg_re_o,
  input logic bus_err_o
);
  AST_WE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R3
  AST_RE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |=> !reg_re_o); // R4
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |=> !bus_err_o); // R7
  AST_ERR_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> !drv_low_o); // R7
  AST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, reg_re_o, bus_err_o})); // R6
  AST_NO_DRIVE_AT_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_re_o |-> !drv_low_o); // R8
  AST_DRIVE_MOVES_ON_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(drv_low_o) |-> ($past(bit_stb_i) || $past(reg_re_o))); // R8
endmodule

bind sw_slave_decoder sw_slave_decoder_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .bit_stb_i(bit_stb_i), .drv_low_o(drv_low_o),
  .reg_we_o(reg_we_o), .reg_re_o(reg_re_o), .bus_err_o(bus_err_o)
);

// File: tb/sw_slave_decoder_tb_top.sv
module sw_slave_decoder_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bit_stb_i = 1'b0;
  logic        bit_i = 1'b1;
  logic        dev_sel_i = 1'b1;
  logic        drv_low_o;
  logic [11:0] reg_addr_o;
  logic        reg_we_o;
  logic [7:0]  reg_wdata_o;
  logic        reg_re_o;
  logic [7:0]  reg_rdata_i;
  logic        bus_err_o;

  int checks = 0, errors = 0;
  int we_cnt, re_cnt, err_cnt, drv_cnt;
  logic [11:0] we_addr, re_addr;
  logic [7:0]  we_data;
  logic        mon_en = 1'b0;

  always #4 clk_i = ~clk_i;

  sw_slave_decoder dut_i (
    .clk_i, .rst_ni, .bit_stb_i, .bit_i, .dev_sel_i, .drv_low_o,
    .reg_addr_o, .reg_we_o, .reg_wdata_o, .reg_re_o, .reg_rdata_i, .bus_err_o
  );

  function automatic logic [7:0] reg_model(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
  endfunction

  function automatic logic [7:0] crc8_ref(input logic [7:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 7; i >= 0; i--)
      c = (c[7] ^ d[i]) ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    return c;
  endfunction

  assign reg_rdata_i = reg_model(reg_addr_o);

  always @(negedge clk_i) if (mon_en) begin
    if (reg_we_o) begin we_cnt++; we_addr = reg_addr_o; we_data = reg_wdata_o; end
    if (reg_re_o) begin re_cnt++; re_addr = reg_addr_o; end
    if (bus_err_o) err_cnt++;
    if (drv_low_o) drv_cnt++;
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b, output logic drv);
    @(negedge clk_i);
    drv = drv_low_o;
    bit_i = b; bit_stb_i = 1'b1;
    @(negedge clk_i);
    bit_stb_i = 1'b0; bit_i = 1'b1;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic send_bits(input logic [15:0] v, input int n);
    logic d;
    for (int i = n - 1; i >= 0; i--) slot(v[i], d);
  endtask

  task automatic recv_bits(input int n, output logic [15:0] v);
    logic d;
    v = '0;
    for (int i = n - 1; i >= 0; i--) begin
      slot(1'b1, d);
      v[i] = ~d;
    end
  endtask

  // one transaction from the host; checks per operation and select
  task automatic txn(input logic [1:0] op, input logic dev, input logic rsv,
                     input logic [3:0] bank, input logic [7:0] offs, input logic [7:0] wd);
    logic [15:0] r;
    logic [11:0] a = {bank, offs};
    logic        match = (dev == dev_sel_i);
    we_cnt = 0; re_cnt = 0; err_cnt = 0; drv_cnt = 0;
    send_bits({op, dev, rsv, bank, offs}, 16);
    if (!match) begin
      if (op == 2'b00 || op == 2'b01) send_bits({8'h00, wd}, 8);
      else if (op == 2'b10)           send_bits({wd, ~wd}, 16);
      repeat (3) @(negedge clk_i);
      chk(we_cnt == 0 && re_cnt == 0 && err_cnt == 0, "R6 no access", we_cnt + re_cnt + err_cnt, 0);
      chk(drv_cnt == 0, "R6 R8 no drive", drv_cnt, 0);
    end else if (op == 2'b00) begin
      send_bits({8'h00, wd}, 8);
      repeat (3) @(negedge clk_i);
      chk(we_cnt == 1, "R3 write pulse", we_cnt, 1);
      chk(we_addr == a, "R2 write addr", we_addr, a);
      chk(we_data == wd, "R3 write data", we_data, wd);
      chk(drv_cnt == 0 && re_cnt == 0, "R8 no drive on write", drv_cnt, 0);
    end else if (op == 2'b11) begin
      repeat (3) @(negedge clk_i);
      chk(err_cnt == 1, "R7 error pulse", err_cnt, 1);
      chk(drv_cnt == 0 && we_cnt == 0 && re_cnt == 0, "R7 quiet", drv_cnt, 0);
    end else begin
      recv_bits(op == 2'b10 ? 16 : 8, r);
      if (op == 2'b01) r = r << 8;
      repeat (2) @(negedge clk_i);
      chk(re_cnt == 1, "R4 read pulse", re_cnt, 1);
      chk(re_addr == a, "R2 R9 read addr", re_addr, a);
      chk(r[15:8] == reg_model(a), "R4 read data", r[15:8], reg_model(a));
      if (op == 2'b10)
        chk(r[7:0] == crc8_ref(reg_model(a)), "R5 crc", r[7:0], crc8_ref(reg_model(a)));
      chk(!drv_low_o, "R8 released after read", drv_low_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!drv_low_o && !reg_we_o && !reg_re_o && !bus_err_o, "R1 reset idle",
        {drv_low_o, reg_we_o, reg_re_o, bus_err_o}, 0);
    mon_en = 1'b1;
    // directed corners
    txn(2'b10, 1'b1, 1'b0, 4'h0, 8'h3C, 8'h00); // R5 data 0x00
    txn(2'b10, 1'b1, 1'b1, 4'h0, 8'hC3, 8'h00); // R5 R9 data 0xFF
    txn(2'b11, 1'b1, 1'b0, 4'h5, 8'h12, 8'h00); // R7
    txn(2'b01, 1'b1, 1'b0, 4'hA, 8'h5A, 8'h00); // R7 next strobe new frame
    txn(2'b10, 1'b0, 1'b0, 4'h1, 8'h00, 8'h00); // R6 zero data during skip
    txn(2'b00, 1'b1, 1'b1, 4'hF, 8'hFF, 8'hA5); // R2 R3 R9
    txn(2'b11, 1'b0, 1'b0, 4'h2, 8'h22, 8'h00); // R6 no skip bits
    txn(2'b01, 1'b1, 1'b0, 4'h3, 8'h33, 8'h00);
    dev_sel_i = 1'b0;
    txn(2'b01, 1'b0, 1'b0, 4'h7, 8'h81, 8'h00); // R4 other strap
    for (int n = 0; n < 60; n++) begin
      if (n % 20 == 0) dev_sel_i = $urandom_range(1, 0);
      txn(2'($urandom_range(3, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
          4'($urandom_range(15, 0)), 8'($urandom_range(255, 0)), 8'($urandom_range(255, 0)));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule